// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven by a single control register. Each write carries a 7-bit key, and while the watchdog is armed a write only takes effect when its key is the bitwise inverse of the key that is already stored. Software that is still alive must therefore keep flipping the key on every service write. A stray write from software that has lost control is unlikely to get past that check.

The counter moves down by one on each slow tick strobe, and the tick rate is produced outside the block. The first time the count runs out, the block raises a non-maskable interrupt level and reloads a short grace count. If the grace count also runs out before an accepted write arrives, the block emits a one-cycle system reset request and stops counting. The current count is brought out so that the surrounding logic can read it back.

Top module: `keyed_wdog`

## Requirements
- R1: During and after reset, the count output is 0, the NMI output and the reset request are low, the counter is stopped, and the stored control word is all zeros, so the watchdog starts out disarmed.
- R2: The control word is 16 bits wide. Bits [15:9] hold the key, bit 8 holds the start command (1 = count, 0 = stop), and bits [7:0] hold the initial count. The stored bit 8 marks the watchdog as armed.
- R3: While the stored start bit is 0, every write is accepted whatever its key.
- R4: While the stored start bit is 1, a write whose key is not the bitwise inverse of the stored key is ignored. It leaves the count, the running state, the NMI output and the stored key unchanged.
- R5: An accepted write stores the whole word and loads the counter from bits [7:0]. A count field of 0 loads 256.
- R6: After an accepted write with bit 8 = 1, the counter decrements on ticks. After an accepted write with bit 8 = 0, the count holds under ticks.
- R7: While the counter is running, each tick lowers the count by exactly one, and the count does not change in a cycle without a tick or a write. A tick that arrives while the count is 1 is an expiry.
- R8: On the first expiry after an accepted write, the NMI output rises, the count reloads to the grace value 10, and counting continues.
- R9: On the next expiry with no accepted write in between, the reset request is high for exactly one cycle while the NMI is still high. The count becomes 0 and counting stops.
- R10: An accepted write drops the NMI output in the next cycle and clears the expiry history, so the next expiry is treated as a first expiry again.
- R11: When an accepted write and a tick arrive in the same cycle, the write takes effect and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickStb | input | 1 | One-cycle count tick strobe |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 16 | Control word: key [15:9], start [8], count [7:0] |
| nmiOut | output | 1 | Non-maskable interrupt level |
| rstReqOut | output | 1 | One-cycle system reset request |
| cntOut | output | 9 | Current count value |

## Verification
A stored key that is wrong cannot be seen directly, but it turns up on the very next write: a correctly inverted service word is dropped, so the count does not reload in the following cycle. A wrong expiry stage shows up at the end of the next countdown, either as an early reset pulse where an NMI was expected or as a second grace reload in place of the reset. A counter that is off by one moves the NMI edge by exactly one tick. For that reason the expected count is compared after every single clock edge, not only at the points where an event occurs.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Strobes from the control module to the datapath; at most one is high per cycle
  typedef struct packed {
    logic loadWr;     // take the written word and its count
    logic loadGrace;  // reload the grace count after the first expiry
    logic zeroCnt;    // clear the count when the reset request fires
    logic decr;       // plain decrement on a tick
  } cntCmd_t;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_GRACE = 1'b1
  } wdgStage_t;

endpackage

// File: rtl/wdg_dpath.sv
module wdg_dpath
  import wdg_pkg::*;
#(
  parameter int KEY_W     = 7,
  parameter int CNT_W     = 8,
  parameter int GRACE_CNT = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cntCmd_t                        cmd,
  input  logic [KEY_W+CNT_W:0]           wrData,
  output logic [KEY_W-1:0]               storedKey,
  output logic                           storedEn,
  output logic                           cntIsOne,
  output logic [CNT_W:0]                 cntQ
);

  localparam int CTRL_W  = KEY_W + 1 + CNT_W;
  localparam int EN_BIT  = CNT_W;
  localparam int KEY_LSB = CNT_W + 1;
  localparam logic [CNT_W:0] FULL_CNT  = (CNT_W+1)'(1) << CNT_W;
  localparam logic [CNT_W:0] GRACE_VAL = (CNT_W+1)'(GRACE_CNT);

  logic [CTRL_W-1:0] ctrlQ;
  logic [CNT_W-1:0]  wrCnt;
  logic [CNT_W:0]    loadVal;

  assign wrCnt   = wrData[CNT_W-1:0];
  assign loadVal = (wrCnt == '0) ? FULL_CNT : {1'b0, wrCnt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (cmd.loadWr) begin
      ctrlQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (cmd.loadWr) begin
      cntQ <= loadVal;
    end else if (cmd.loadGrace) begin
      cntQ <= GRACE_VAL;
    end else if (cmd.zeroCnt) begin
      cntQ <= '0;
    end else if (cmd.decr) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign storedKey = ctrlQ[CTRL_W-1:KEY_LSB];
  assign storedEn  = ctrlQ[EN_BIT];
  assign cntIsOne  = (cntQ == (CNT_W+1)'(1));

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int KEY_W = 7,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickStb,
  input  logic                 wrEn,
  input  logic [KEY_W+CNT_W:0] wrData,
  input  logic [KEY_W-1:0]     storedKey,
  input  logic                 storedEn,
  input  logic                 cntIsOne,
  output cntCmd_t              cmd,
  output logic                 nmiQ,
  output logic                 rstReqQ
);

  localparam int CTRL_W  = KEY_W + 1 + CNT_W;
  localparam int KEY_LSB = CNT_W + 1;

  logic [KEY_W-1:0] wrKey;
  logic [KEY_W-1:0] wantKey;
  logic             keyOk;
  logic             accept;
  logic             runQ;
  logic             expire;
  wdgStage_t        stageQ;

  assign wrKey   = wrData[CTRL_W-1:KEY_LSB];
  assign wantKey = ~storedKey;
  assign keyOk   = (wrKey == wantKey);
  assign accept  = wrEn && (!storedEn || keyOk);
  assign expire  = !accept && runQ && tickStb && cntIsOne;

  always_comb begin
    cmd           = '0;
    cmd.loadWr    = accept;
    cmd.loadGrace = expire && (stageQ == ST_ARMED);
    cmd.zeroCnt   = expire && (stageQ == ST_GRACE);
    cmd.decr      = !accept && !expire && runQ && tickStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      stageQ  <= ST_ARMED;
      nmiQ    <= 1'b0;
      rstReqQ <= 1'b0;
    end else begin
      rstReqQ <= expire && (stageQ == ST_GRACE);
      if (accept) begin
        runQ   <= wrData[CNT_W];
        stageQ <= ST_ARMED;
        nmiQ   <= 1'b0;
      end else if (expire) begin
        if (stageQ == ST_ARMED) begin
          stageQ <= ST_GRACE;
          nmiQ   <= 1'b1;
        end else begin
          runQ <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdg_pkg::*;
#(
  parameter int KEY_W     = 7,
  parameter int CNT_W     = 8,
  parameter int GRACE_CNT = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickStb,
  input  logic                 wrEn,
  input  logic [KEY_W+CNT_W:0] wrData,
  output logic                 nmiOut,
  output logic                 rstReqOut,
  output logic [CNT_W:0]       cntOut
);

  cntCmd_t          cmd;
  logic [KEY_W-1:0] storedKey;
  logic             storedEn;
  logic             cntIsOne;

  wdg_ctrl #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickStb   (tickStb),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .storedKey (storedKey),
    .storedEn  (storedEn),
    .cntIsOne  (cntIsOne),
    .cmd       (cmd),
    .nmiQ      (nmiOut),
    .rstReqQ   (rstReqOut)
  );

  wdg_dpath #(.KEY_W(KEY_W), .CNT_W(CNT_W), .GRACE_CNT(GRACE_CNT)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wrData    (wrData),
    .storedKey (storedKey),
    .storedEn  (storedEn),
    .cntIsOne  (cntIsOne),
    .cntQ      (cntOut)
  );

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int KEY_W     = 7,
  parameter int CNT_W     = 8,
  parameter int GRACE_CNT = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickStb,
  input logic                 wrEn,
  input logic [KEY_W+CNT_W:0] wrData,
  input logic                 nmiOut,
  input logic                 rstReqOut,
  input logic [CNT_W:0]       cntOut,
  input logic [KEY_W-1:0]     storedKey,
  input logic                 storedEn
);

  localparam int KEY_LSB = CNT_W + 1;
  localparam int CTRL_W  = KEY_W + 1 + CNT_W;

  logic [KEY_W-1:0] invKey;
  logic             goodWr;
  logic             badWr;
  logic [CNT_W:0]   expLoad;

  assign invKey  = ~storedKey;
  assign goodWr  = wrEn && (!storedEn || (wrData[CTRL_W-1:KEY_LSB] == invKey));
  assign badWr   = wrEn && storedEn && (wrData[CTRL_W-1:KEY_LSB] != invKey);
  assign expLoad = (wrData[CNT_W-1:0] == '0) ? ((CNT_W+1)'(1) << CNT_W)
                                             : {1'b0, wrData[CNT_W-1:0]};

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |=> !rstReqOut); // R9
  AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |-> nmiOut); // R9
  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !tickStb) |=> $stable(cntOut)); // R7
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (badWr && !tickStb) |=> ($stable(cntOut) && $stable(nmiOut) && $stable(storedKey))); // R4
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    goodWr |=> (cntOut == $past(expLoad))); // R5
  AST_WRITE_CLEARS_NMI: assert property (@(posedge clk) disable iff (!rstN)
    goodWr |=> !nmiOut); // R10
  AST_GRACE_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiOut) |-> (cntOut == (CNT_W+1)'(GRACE_CNT))); // R8

endmodule

bind keyed_wdog wdg_checker #(.KEY_W(KEY_W), .CNT_W(CNT_W), .GRACE_CNT(GRACE_CNT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickStb   (tickStb),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .nmiOut    (nmiOut),
  .rstReqOut (rstReqOut),
  .cntOut    (cntOut),
  .storedKey (storedKey),
  .storedEn  (storedEn)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickStb = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        nmiOut;
  logic        rstReqOut;
  logic [8:0]  cntOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyed_wdog u_keyed_wdog (
    .clk(clk), .rstN(rstN), .tickStb(tickStb), .wrEn(wrEn),
    .wrData(wrData), .nmiOut(nmiOut), .rstReqOut(rstReqOut), .cntOut(cntOut)
  );

  typedef struct {
    int    cnt;
    bit    nmi;
    bit    rst;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference model state, built from the requirements
  logic [15:0] mCtrl = '0;
  int          mCnt = 0;
  bit          mRun = 0;
  bit          mGrace = 0;
  bit          mNmi = 0;
  bit          mRst = 0;

  function automatic logic [15:0] word(input logic [6:0] key, input bit start, input logic [7:0] cnt);
    return {key, start, cnt};
  endfunction

  task automatic step(input bit t, input bit w, input logic [15:0] d, input string tag);
    logic [6:0] inv;
    bit acc;
    bit expd;
    expItem_t it;
    @(negedge clk);
    tickStb = t;
    wrEn    = w;
    wrData  = d;
    @(posedge clk);
    #1;
    tickStb = 1'b0;
    wrEn    = 1'b0;
    inv  = ~mCtrl[15:9];
    acc  = w && (!mCtrl[8] || d[15:9] == inv);
    expd = !acc && mRun && t && mCnt == 1;
    mRst = 0;
    if (acc) begin
      mCtrl  = d;
      mCnt   = (d[7:0] == 0) ? 256 : int'(d[7:0]);
      mRun   = d[8];
      mGrace = 0;
      mNmi   = 0;
    end else if (expd) begin
      if (!mGrace) begin
        mNmi = 1; mCnt = 10; mGrace = 1;
      end else begin
        mRst = 1; mCnt = 0; mRun = 0;
      end
    end else if (mRun && t && mCnt != 0) begin
      mCnt = mCnt - 1;
    end
    it.cnt = mCnt; it.nmi = mNmi; it.rst = mRst; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, tag);
  endtask

  // Monitor: compare after each edge, away from the edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (int'(cntOut) != e.cnt || nmiOut != e.nmi || rstReqOut != e.rst) begin
        errors++;
        $display("FAIL %s: cnt=%0d nmi=%0b rst=%0b expected cnt=%0d nmi=%0b rst=%0b",
                 e.tag, cntOut, nmiOut, rstReqOut, e.cnt, e.nmi, e.rst);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cntOut != 0 || nmiOut || rstReqOut) begin
      errors++;
      $display("FAIL R1: cnt=%0d nmi=%0b rst=%0b expected 0 0 0", cntOut, nmiOut, rstReqOut);
    end
    rstN = 1'b1;
    step(0, 0, '0, "R1 idle");
    ticks(3, "R6 stopped after reset");
    // Disarmed: any key accepted
    step(0, 1, word(7'h15, 1, 8'd5), "R3 R2 first load");
    ticks(2, "R7 decrement");
    step(0, 0, '0, "R7 hold without tick");
    // Wrong key while armed
    step(0, 1, word(7'h15, 1, 8'd20), "R4 same key ignored");
    step(1, 1, word(7'h00, 1, 8'd20), "R4 bad key with tick");
    // Correct inverse key, count 0 means 256
    step(0, 1, word(7'h6A, 1, 8'd0), "R5 zero loads 256");
    ticks(2, "R7 decrement from 256");
    // Write and tick together
    step(1, 1, word(7'h15, 1, 8'd3), "R11 write beats tick");
    ticks(2, "R7 countdown");
    ticks(1, "R8 first expiry");
    ticks(3, "R8 grace counting");
    step(0, 1, word(7'h6A, 1, 8'd4), "R10 service clears NMI");
    ticks(4, "R10 expiry is first again");
    ticks(9, "R8 grace");
    ticks(1, "R9 reset request");
    step(0, 0, '0, "R9 single pulse");
    ticks(3, "R9 stopped");
    // Armed still: key must be inverse of 0x6A
    step(0, 1, word(7'h2A, 0, 8'd7), "R4 wrong key after reset request");
    step(0, 1, word(7'h15, 0, 8'd7), "R6 stop command");
    ticks(4, "R6 held while stopped");
    // Now disarmed: arbitrary key accepted
    step(0, 1, word(7'h33, 1, 8'd1), "R3 any key while disarmed");
    ticks(1, "R8 expiry from count 1");
    step(0, 1, word(7'h33, 1, 8'd9), "R4 non-inverse rejected");
    step(0, 1, word(7'h4C, 1, 8'd2), "R10 inverse accepted");
    ticks(2, "R8 expiry again");
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule